// File: doc/BRIEF.md
# SPI FIFO status flag generator

This block produces the live 32-bit status word of one SPI channel. It keeps an occupancy counter for the transmit FIFO and one for the receive FIFO. From these counters it derives level flags and look-ahead flags that warn one access in advance. It also raises error flags when the shift engine meets an empty transmit FIFO or a full receive FIFO. Two frame-completion flags rise once a programmed number of frames has been sent or received.

Software pushes words into the transmit side and pops words from the receive side. The shift engine asks for one transmit word per frame and delivers one receive word per frame. The status word is combinational from registered state, so it always shows current conditions. No bit is sticky: every flag drops as soon as its condition is gone. Data storage, the serial shifter and interrupt masking sit outside this block.

Top module: `spi_stat_gen`

## Requirements
- R1: While reset is held, and right after reset with `busy_i` and `ss_level_i` low, `status_o` equals 0x0000_0440. Bits 10 and 6 are high and every other bit is low, for any depth above 1.
- R2: Bit 10 (transmit) and bit 6 (receive) are high when the FIFO holds no words. Bit 8 (transmit) and bit 4 (receive) are high when it holds exactly its depth.
- R3: Bits 11 and 7 are high when the transmit or receive FIFO holds exactly one word. Bits 9 and 5 are high when it holds depth minus one words. With a depth of 1, bit 11 equals NOT bit 10, bit 9 equals NOT bit 8, bit 7 equals NOT bit 6, and bit 5 equals NOT bit 4.
- R4: A push into a full FIFO and a pop from an empty FIFO are dropped and leave its level unchanged. A simultaneous push and pop on a non-empty, non-full FIFO leaves the level unchanged.
- R5: Bit 3 (underrun) is set by a `tx_req_i` that finds the transmit FIFO empty, but only when `slave_mode_i` is 1. In master mode such a request is ignored.
- R6: Bit 2 (overflow) is set by an `rx_done_i` that finds the receive FIFO full, in either mode.
- R7: An error flag stays high until an accepted push or pop on its own FIFO, or until `soft_clr_i`. `soft_clr_i` wins over a new setting event, and a setting event wins over a same-cycle accepted access.
- R8: Bit 0 is high when the count of accepted transmit pops equals a nonzero programmed target. Bit 1 is the same for accepted receive pushes. Each count stops at the target, and a target of 0 never sets these bits.
- R9: `frame_tgt_we_i` loads a new target, and either it or `start_i` returns both frame counts to zero.
- R10: Bit 14 follows `busy_i` and bit 13 follows `ss_level_i` in the same cycle. Bits 31:15 and bit 12 read 0.
- R11: Bits 11:0 change only in the cycle after the clock edge that samples the strobe causing the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slave_mode_i | input | 1 | 1 = slave, 0 = master |
| ss_level_i | input | 1 | Current level of slave-select line 0 |
| busy_i | input | 1 | Shift engine has a transfer in progress |
| tx_push_i | input | 1 | Software writes a word into the transmit FIFO |
| tx_req_i | input | 1 | Shifter takes one transmit word for a frame |
| rx_done_i | input | 1 | Shifter delivers one received frame |
| rx_pop_i | input | 1 | Software reads a word from the receive FIFO |
| soft_clr_i | input | 1 | Clears both error flags |
| frame_tgt_i | input | CNT_W | Frame count target value |
| frame_tgt_we_i | input | 1 | Loads `frame_tgt_i` and restarts the frame counts |
| start_i | input | 1 | Restarts the frame counts |
| status_o | output | 32 | Live status word |

## Verification
The hardest cases to reach are the priority collisions around the error flags. One is a full receive FIFO that gets a delivered frame, a software read and possibly a soft clear, all in the same cycle. The other is the slave-mode underrun that arrives just as software pushes its first word. Directed sequences fill and drain each FIFO to its edge and then stack these strobes in one cycle. A long seeded random phase then toggles mode, target writes and restarts while the whole word is compared every cycle. A depth-1 instance runs on the same stimulus to hold the look-ahead equivalence.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int unsigned STAT_W      = 32;
  localparam int unsigned B_ACTIVE    = 14;
  localparam int unsigned B_SS        = 13;
  localparam int unsigned B_TX_E_NXT  = 11;
  localparam int unsigned B_TX_EMPTY  = 10;
  localparam int unsigned B_TX_F_NXT  = 9;
  localparam int unsigned B_TX_FULL   = 8;
  localparam int unsigned B_RX_E_NXT  = 7;
  localparam int unsigned B_RX_EMPTY  = 6;
  localparam int unsigned B_RX_F_NXT  = 5;
  localparam int unsigned B_RX_FULL   = 4;
  localparam int unsigned B_UNDERRUN  = 3;
  localparam int unsigned B_OVERFLOW  = 2;
  localparam int unsigned B_RX_DONE   = 1;
  localparam int unsigned B_TX_DONE   = 0;

  typedef struct packed {
    logic empty_nxt;
    logic empty;
    logic full_nxt;
    logic full;
  } fifo_flags_t;
endpackage

// File: rtl/spi_fifo_lvl.sv
module spi_fifo_lvl
  import spi_stat_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        push_i,
  input  logic        pop_i,
  output logic        push_ok_o,
  output logic        pop_ok_o,
  output fifo_flags_t flags_o
);
  localparam int unsigned LW = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);
  localparam logic [LW-1:0] LVL_NXTF = LW'(DEPTH - 1);
  localparam logic [LW-1:0] LVL_ONE  = LW'(1);

  logic [LW-1:0] level_q;

  assign flags_o.empty     = (level_q == '0);
  assign flags_o.full      = (level_q == LVL_FULL);
  assign flags_o.empty_nxt = (level_q == LVL_ONE);
  assign flags_o.full_nxt  = (level_q == LVL_NXTF);

  assign push_ok_o = push_i & ~flags_o.full;
  assign pop_ok_o  = pop_i  & ~flags_o.empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      level_q <= '0;
    else if (push_ok_o && !pop_ok_o)
      level_q <= level_q + LVL_ONE;
    else if (pop_ok_o && !push_ok_o)
      level_q <= level_q - LVL_ONE;
  end

  AST_LVL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LVL_FULL); // R2
  AST_FULL_PUSH_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o.full && push_i && !pop_i |=> flags_o.full); // R4
  AST_EMPTY_POP_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o.empty && pop_i && !push_i |=> flags_o.empty); // R4
  AST_BOTH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_i && !flags_o.full && !flags_o.empty |=> $stable(level_q)); // R4
endmodule

// File: rtl/spi_err_flag.sv
module spi_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic soft_clr_i,
  output logic flag_o
);
  // priority: soft clear > set > access clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_o <= 1'b0;
    else if (soft_clr_i) flag_o <= 1'b0;
    else if (set_i)      flag_o <= 1'b1;
    else if (clr_i)      flag_o <= 1'b0;
  end

  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && !soft_clr_i |=> flag_o); // R7
  AST_ERR_SOFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_clr_i |=> !flag_o); // R7
  AST_ERR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !clr_i && !soft_clr_i |=> flag_o); // R7
endmodule

// File: rtl/spi_frame_tally.sv
module spi_frame_tally #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] target_i,
  input  logic             restart_i,
  input  logic             inc_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = (target_i != '0) && (cnt_q == target_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      cnt_q <= '0;
    else if (restart_i)
      cnt_q <= '0;
    else if (inc_i && (cnt_q < target_i))
      cnt_q <= cnt_q + CNT_W'(1);
  end

  AST_TALLY_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !done_o); // R9
  AST_TALLY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !restart_i |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/spi_stat_gen.sv
module spi_stat_gen
  import spi_stat_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 8,
  parameter int unsigned RX_DEPTH = 8,
  parameter int unsigned CNT_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slave_mode_i,
  input  logic             ss_level_i,
  input  logic             busy_i,
  input  logic             tx_push_i,
  input  logic             tx_req_i,
  input  logic             rx_done_i,
  input  logic             rx_pop_i,
  input  logic             soft_clr_i,
  input  logic [CNT_W-1:0] frame_tgt_i,
  input  logic             frame_tgt_we_i,
  input  logic             start_i,
  output logic [31:0]      status_o
);
  fifo_flags_t      tx_f, rx_f;
  logic             tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic             underrun, overflow, tx_done, rx_done;
  logic [CNT_W-1:0] target_q;
  logic             restart;

  assign restart = frame_tgt_we_i | start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             target_q <= '0;
    else if (frame_tgt_we_i) target_q <= frame_tgt_i;
  end

  spi_fifo_lvl #(.DEPTH(TX_DEPTH)) u_tx_lvl (
    .clk_i, .rst_ni,
    .push_i(tx_push_i), .pop_i(tx_req_i),
    .push_ok_o(tx_push_ok), .pop_ok_o(tx_pop_ok), .flags_o(tx_f)
  );

  spi_fifo_lvl #(.DEPTH(RX_DEPTH)) u_rx_lvl (
    .clk_i, .rst_ni,
    .push_i(rx_done_i), .pop_i(rx_pop_i),
    .push_ok_o(rx_push_ok), .pop_ok_o(rx_pop_ok), .flags_o(rx_f)
  );

  // a master never starts a frame without data, so only a slave can underrun
  spi_err_flag u_urun (
    .clk_i, .rst_ni,
    .set_i(tx_req_i & tx_f.empty & slave_mode_i),
    .clr_i(tx_push_ok | tx_pop_ok),
    .soft_clr_i, .flag_o(underrun)
  );

  spi_err_flag u_ovf (
    .clk_i, .rst_ni,
    .set_i(rx_done_i & rx_f.full),
    .clr_i(rx_push_ok | rx_pop_ok),
    .soft_clr_i, .flag_o(overflow)
  );

  spi_frame_tally #(.CNT_W(CNT_W)) u_tx_tally (
    .clk_i, .rst_ni, .target_i(target_q), .restart_i(restart),
    .inc_i(tx_pop_ok), .done_o(tx_done)
  );

  spi_frame_tally #(.CNT_W(CNT_W)) u_rx_tally (
    .clk_i, .rst_ni, .target_i(target_q), .restart_i(restart),
    .inc_i(rx_push_ok), .done_o(rx_done)
  );

  always_comb begin
    status_o             = '0;
    status_o[B_ACTIVE]   = busy_i;
    status_o[B_SS]       = ss_level_i;
    status_o[B_TX_E_NXT] = tx_f.empty_nxt;
    status_o[B_TX_EMPTY] = tx_f.empty;
    status_o[B_TX_F_NXT] = tx_f.full_nxt;
    status_o[B_TX_FULL]  = tx_f.full;
    status_o[B_RX_E_NXT] = rx_f.empty_nxt;
    status_o[B_RX_EMPTY] = rx_f.empty;
    status_o[B_RX_F_NXT] = rx_f.full_nxt;
    status_o[B_RX_FULL]  = rx_f.full;
    status_o[B_UNDERRUN] = underrun;
    status_o[B_OVERFLOW] = overflow;
    status_o[B_RX_DONE]  = rx_done;
    status_o[B_TX_DONE]  = tx_done;
  end

  AST_URUN_SLAVE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[B_UNDERRUN]) |-> $past(slave_mode_i)); // R5
  AST_OVF_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[B_OVERFLOW]) |-> $past(status_o[B_RX_FULL])); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[31:15] == '0 && !status_o[12]); // R10
  AST_TXDONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[B_TX_DONE]) |-> $past(tx_pop_ok)); // R11
endmodule

// File: tb/tb_spi_stat_gen.sv
module tb_spi_stat_gen;
  localparam int D = 4;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slave = 0, ss = 0, busy = 0, tx_push = 0, tx_req = 0, rx_done = 0;
  logic rx_pop = 0, soft_clr = 0, tgt_we = 0, start = 0;
  logic [CW-1:0] tgt_val = '0;
  logic [31:0] status, status_d1;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  int tx_lvl, rx_lvl, scnt, rcnt, tgt;
  bit urun, ovf;

  always #10 clk = ~clk;

  spi_stat_gen #(.TX_DEPTH(D), .RX_DEPTH(D), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .slave_mode_i(slave), .ss_level_i(ss),
    .busy_i(busy), .tx_push_i(tx_push), .tx_req_i(tx_req), .rx_done_i(rx_done),
    .rx_pop_i(rx_pop), .soft_clr_i(soft_clr), .frame_tgt_i(tgt_val),
    .frame_tgt_we_i(tgt_we), .start_i(start), .status_o(status));

  spi_stat_gen #(.TX_DEPTH(1), .RX_DEPTH(1), .CNT_W(CW)) dut_d1 (
    .clk_i(clk), .rst_ni(rst_n), .slave_mode_i(slave), .ss_level_i(ss),
    .busy_i(busy), .tx_push_i(tx_push), .tx_req_i(tx_req), .rx_done_i(rx_done),
    .rx_pop_i(rx_pop), .soft_clr_i(soft_clr), .frame_tgt_i(tgt_val),
    .frame_tgt_we_i(tgt_we), .start_i(start), .status_o(status_d1));

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    s[14] = busy;          s[13] = ss;
    s[11] = tx_lvl == 1;   s[10] = tx_lvl == 0;
    s[9]  = tx_lvl == D-1; s[8]  = tx_lvl == D;
    s[7]  = rx_lvl == 1;   s[6]  = rx_lvl == 0;
    s[5]  = rx_lvl == D-1; s[4]  = rx_lvl == D;
    s[3]  = urun;          s[2]  = ovf;
    s[1]  = (tgt != 0) && (rcnt == tgt);
    s[0]  = (tgt != 0) && (scnt == tgt);
    return s;
  endfunction

  task automatic model_reset();
    tx_lvl = 0; rx_lvl = 0; scnt = 0; rcnt = 0; tgt = 0; urun = 0; ovf = 0;
  endtask

  task automatic model_edge();
    bit txp, txq, rxp, rxq, rst_cnt;
    txp = tx_push && tx_lvl < D;
    txq = tx_req && tx_lvl > 0;
    rxp = rx_done && rx_lvl < D;
    rxq = rx_pop && rx_lvl > 0;
    rst_cnt = tgt_we || start;
    if (soft_clr) urun = 0;
    else if (tx_req && tx_lvl == 0 && slave) urun = 1;
    else if (txp || txq) urun = 0;
    if (soft_clr) ovf = 0;
    else if (rx_done && rx_lvl == D) ovf = 1;
    else if (rxp || rxq) ovf = 0;
    if (rst_cnt) begin scnt = 0; rcnt = 0; end
    else begin
      if (txq && scnt < tgt) scnt++;
      if (rxp && rcnt < tgt) rcnt++;
    end
    if (tgt_we) tgt = int'(tgt_val);
    tx_lvl += int'(txp) - int'(txq);
    rx_lvl += int'(rxp) - int'(rxq);
  endtask

  task automatic check(input string lbl, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FIFO status FAIL %s: got %h expected %h", lbl, got, exp);
    end
  endtask

  task automatic check_d1(input string lbl);
    check({lbl, " R3 depth1"}, {28'd0, status_d1[11], status_d1[9], status_d1[7], status_d1[5]},
          {28'd0, ~status_d1[10], ~status_d1[8], ~status_d1[6], ~status_d1[4]});
  endtask

  task automatic step(input string lbl);
    @(posedge clk);
    model_edge();
    #1;
    check(lbl, status, exp_status());
    check_d1(lbl);
    tx_push = 0; tx_req = 0; rx_done = 0; rx_pop = 0;
    soft_clr = 0; tgt_we = 0; start = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FIFO status FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", status, 32'h0000_0440);
    rst_n = 1'b1;
    #1;
    check("R1 after reset", status, 32'h0000_0440);
    check("R3 depth1 reset", status_d1, 32'h0000_0660);

    tgt_val = 16'd3; tgt_we = 1; step("R9 target write");
    for (int i = 0; i < D; i++) begin tx_push = 1; step("R2 R3 tx fill"); end
    tx_push = 1; step("R4 push to full ignored");
    tx_push = 1; tx_req = 1; step("R4 push and pop at full");
    for (int i = 0; i < 3; i++) begin tx_req = 1; step("R8 sent count"); end
    tx_req = 1; step("R8 halt at target");
    tx_req = 1; step("R5 master no underrun");
    slave = 1; tx_req = 1; step("R5 slave underrun");
    tx_req = 1; step("R7 underrun holds");
    tx_push = 1; tx_req = 1; step("R7 set beats push");
    tx_push = 1; step("R7 cleared by push");
    for (int i = 0; i < D; i++) begin rx_done = 1; step("R6 R8 rx fill"); end
    rx_done = 1; step("R6 overflow");
    rx_done = 1; soft_clr = 1; step("R7 soft clear priority");
    rx_done = 1; slave = 0; step("R6 overflow master");
    rx_done = 1; rx_pop = 1; step("R7 set beats access");
    rx_pop = 1; step("R7 cleared by pop");
    for (int i = 0; i < D + 1; i++) begin rx_pop = 1; step("R4 rx drain"); end
    start = 1; step("R9 start restart");
    tgt_val = 16'd0; tgt_we = 1; step("R9 zero target");
    rx_done = 1; step("R8 zero target never done");
    busy = 1; ss = 1; #1; check("R10 live bits", status, exp_status());
    tx_push = 1; #1; check("R11 no change before edge", status, exp_status());
    step("R11 change after edge");
    busy = 0; ss = 0;

    for (int c = 0; c < 4000; c++) begin
      tx_push  = ($urandom % 100) < 45;
      tx_req   = ($urandom % 100) < 40;
      rx_done  = ($urandom % 100) < 40;
      rx_pop   = ($urandom % 100) < 40;
      soft_clr = ($urandom % 100) < 3;
      start    = ($urandom % 100) < 2;
      tgt_we   = ($urandom % 100) < 3;
      tgt_val  = CW'($urandom % 7);
      if (($urandom % 50) == 0) slave = ~slave;
      busy = $urandom % 2;
      ss   = $urandom % 2;
      step("R11 random");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule